// File: doc/BRIEF.md
# Byte-Addressed Serial EEPROM Target

This block is a two-wire serial bus target that behaves like a 256-byte serial EEPROM. The storage is a bank of on-chip registers, loaded from a parameter image at reset. The block works from a system clock that is much faster than the bus. It synchronizes SCL and SDA, detects START and STOP conditions, shifts bytes in and out, and pulls SDA low through an output-enable. The data line itself is open-drain and lives outside the block.

The target keeps one 8-bit location pointer. A write with a single byte moves that pointer. A longer write stores bytes from a start location given by its first byte, and the pointer does not move. A read streams bytes from the pointer and advances it. A write that carries one byte, followed by a repeated START and a read, returns data from that byte's location. No transfer carries a byte count: every byte the host clocks counts as data.

There is no valid/ready handshake. The bus gives no back-pressure, because the target never holds SCL low. Each byte is therefore taken or supplied within the host's own bit timing, and no transfer can be refused once its address is acknowledged.

Top module: `i2c_eeprom_target`

## Requirements
- R1: The target answers to the 7-bit address 0x50 + strap_idx. The address byte is sent MSB first, as seven address bits and then a direction bit (1 = read). Any other address gets no acknowledge, and the target leaves SDA alone until the next START.
- R2: The target holds sda_oe high through the ninth SCL pulse after a matching address byte and after every byte the host writes. It never drives SDA while the host is sending bits.
- R3: After reset the pointer is 0. With the default image, the byte at location k holds k XOR 0xA5.
- R4: A write transfer with exactly one byte after the address loads the pointer with that byte and stores nothing.
- R5: A read returns the byte at the pointer, MSB first, with sda_oe high for each 0 bit. The pointer then steps by one modulo 256, so reading past location 255 continues at 0.
- R6: In a write of two or more bytes, the first byte is the start location. The following bytes go to successive locations, and location 255 is followed by location 0. The pointer keeps its value.
- R7: If a one-byte write is followed by a repeated START and a read, the read starts at the location that byte named and then continues in sequence.
- R8: A write-direction address followed directly by STOP is acknowledged and changes neither the pointer nor the contents.
- R9: When the host answers a read byte with NACK, the target releases SDA and keeps it released until the next START. The NACKed byte still counts as delivered for the pointer.
- R10: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A repeated START restarts address decoding without any STOP. sda_oe changes only just after an SCL falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low reset; reloads the image and clears the pointer |
| strap_idx | input | 3 | Instance index added to the base address |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | High to pull SDA low |

## Verification
The assertions assume a legal bus. SDA changes only while SCL is low, except at START and STOP. Each SCL phase lasts longer than the synchronizer delay plus one cycle. The host never tries to create START or STOP while the target holds SDA low. On those assumptions, output-enable changes follow SCL falling edges and the pointer only steps or reloads. The stimulus respects them: the host moves SDA a quarter bit-period after SCL falls, holds every SCL phase for sixteen system clocks, and releases SDA whenever the target should be driving.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;

  localparam int EE_AW    = 8;
  localparam int EE_DEPTH = 1 << EE_AW;
  localparam int BYTE_W   = 8;
  localparam int BIT_CW   = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    LK_IDLE,
    LK_ADDR,
    LK_AACK,
    LK_RX,
    LK_WACK,
    LK_TX,
    LK_HACK
  } link_st_e;

  // Default preload: location k holds k XOR 0xA5
  function automatic logic [BYTE_W*EE_DEPTH-1:0] ee_image();
    logic [BYTE_W*EE_DEPTH-1:0] img;
    img = '0;
    for (int k = 0; k < EE_DEPTH; k++) begin
      img[BYTE_W*k +: BYTE_W] = BYTE_W'(k) ^ 8'hA5;
    end
    return img;
  endfunction

endpackage

// File: rtl/i2c_ee_line_sync.sv
module i2c_ee_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);

  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_v;
  logic [NLINES-1:0] sync_v;
  logic [NLINES-1:0] prev_v;

  assign raw_v = {scl_raw, sda_raw};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [STAGES-1:0] pipe_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pipe_q    <= '1;
        prev_v[g] <= 1'b1;
      end else begin
        pipe_q    <= {pipe_q[STAGES-2:0], raw_v[g]};
        prev_v[g] <= pipe_q[STAGES-1];
      end
    end
    assign sync_v[g] = pipe_q[STAGES-1];
  end

  logic scl_s, scl_q, sda_q;
  assign scl_s = sync_v[1];
  assign sda_s = sync_v[0];
  assign scl_q = prev_v[1];
  assign sda_q = prev_v[0];

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_ee_store.sv
module i2c_ee_store #(
  parameter int ADDR_W = i2c_ee_pkg::EE_AW,
  parameter int DATA_W = i2c_ee_pkg::BYTE_W,
  parameter logic [DATA_W*(1<<ADDR_W)-1:0] INIT = i2c_ee_pkg::ee_image()
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cell_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cell_q[g] <= INIT[DATA_W*g +: DATA_W];
      end else if (we && (waddr == ADDR_W'(g))) begin
        cell_q[g] <= wdata;
      end
    end
  end

  assign rdata = cell_q[raddr];

endmodule

// File: rtl/i2c_ee_link.sv
module i2c_ee_link
  import i2c_ee_pkg::*;
#(
  parameter int ADDR_W = EE_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_c,
  input  logic              stop_c,
  input  logic [6:0]        dev_addr,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic [ADDR_W-1:0] ptr_q
);

  localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(BYTE_W - 1);

  link_st_e          st_q;
  logic [BIT_CW-1:0] bit_q;
  logic [BYTE_W-1:0] rx_q;
  logic [BYTE_W-1:0] tx_q;
  logic              full_q;
  logic              rw_q;
  logic              nack_q;
  logic              oe_q;
  logic              sess_q;
  logic [1:0]        nbytes_q;
  logic [ADDR_W-1:0] cmd_q;
  logic [ADDR_W-1:0] wptr_q;

  // A data byte (not the command byte) completes in the write phase
  assign mem_we    = (st_q == LK_RX) && scl_fall && full_q && (nbytes_q != 2'd0);
  assign mem_waddr = wptr_q;
  assign mem_wdata = rx_q;
  assign sda_oe    = oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= LK_IDLE;
      bit_q    <= '0;
      rx_q     <= '0;
      tx_q     <= '0;
      full_q   <= 1'b0;
      rw_q     <= 1'b0;
      nack_q   <= 1'b0;
      oe_q     <= 1'b0;
      sess_q   <= 1'b0;
      nbytes_q <= '0;
      cmd_q    <= '0;
      wptr_q   <= '0;
      ptr_q    <= '0;
    end else if (start_c || stop_c) begin
      // Close a write phase: a lone byte becomes the new pointer
      if (sess_q && (nbytes_q == 2'd1)) ptr_q <= cmd_q;
      sess_q <= 1'b0;
      oe_q   <= 1'b0;
      bit_q  <= '0;
      full_q <= 1'b0;
      st_q   <= start_c ? LK_ADDR : LK_IDLE;
    end else begin
      unique case (st_q)
        LK_IDLE: ;
        LK_ADDR, LK_RX: begin
          if (scl_rise) begin
            rx_q  <= {rx_q[BYTE_W-2:0], sda_s};
            bit_q <= bit_q + 1'b1;
            if (bit_q == LAST_BIT) full_q <= 1'b1;
          end else if (scl_fall && full_q) begin
            full_q <= 1'b0;
            bit_q  <= '0;
            if (st_q == LK_ADDR) begin
              if (rx_q[BYTE_W-1:1] == dev_addr) begin
                st_q     <= LK_AACK;
                oe_q     <= 1'b1;
                rw_q     <= rx_q[0];
                nbytes_q <= '0;
              end else begin
                st_q <= LK_IDLE;
              end
            end else begin
              if (nbytes_q == 2'd0) begin
                cmd_q  <= ADDR_W'(rx_q);
                wptr_q <= ADDR_W'(rx_q);
              end else begin
                wptr_q <= wptr_q + 1'b1;
              end
              if (nbytes_q != 2'd3) nbytes_q <= nbytes_q + 1'b1;
              oe_q <= 1'b1;
              st_q <= LK_WACK;
            end
          end
        end
        LK_AACK: begin
          if (scl_fall) begin
            bit_q <= '0;
            if (rw_q) begin
              tx_q <= rd_data;
              oe_q <= ~rd_data[BYTE_W-1];
              st_q <= LK_TX;
            end else begin
              oe_q   <= 1'b0;
              sess_q <= 1'b1;
              st_q   <= LK_RX;
            end
          end
        end
        LK_WACK: begin
          if (scl_fall) begin
            oe_q <= 1'b0;
            st_q <= LK_RX;
          end
        end
        LK_TX: begin
          if (scl_fall) begin
            if (bit_q == LAST_BIT) begin
              oe_q <= 1'b0;
              st_q <= LK_HACK;
            end else begin
              oe_q  <= ~tx_q[BYTE_W-2];
              tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
              bit_q <= bit_q + 1'b1;
            end
          end
        end
        LK_HACK: begin
          if (scl_rise) begin
            nack_q <= sda_s;
            ptr_q  <= ptr_q + 1'b1;
          end else if (scl_fall) begin
            bit_q <= '0;
            if (nack_q) begin
              st_q <= LK_IDLE;
            end else begin
              tx_q <= rd_data;
              oe_q <= ~rd_data[BYTE_W-1];
              st_q <= LK_TX;
            end
          end
        end
        default: st_q <= LK_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
  import i2c_ee_pkg::*;
#(
  parameter int         ADDR_W      = EE_AW,
  parameter logic [6:0] DEV_BASE    = 7'h50,
  parameter int         IDX_W       = 3,
  parameter int         SYNC_STAGES = 2,
  parameter logic [BYTE_W*(1<<ADDR_W)-1:0] INIT_IMAGE = ee_image()
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] strap_idx,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             sda_oe
);

  logic              sda_s;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_c;
  logic              stop_c;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [BYTE_W-1:0] mem_wdata;
  logic [BYTE_W-1:0] rd_data;
  logic [ADDR_W-1:0] ptr_q;
  logic [6:0]        dev_addr;

  assign dev_addr = DEV_BASE + 7'(strap_idx);

  i2c_ee_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_raw  (scl_in),
    .sda_raw  (sda_in),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_c  (start_c),
    .stop_c   (stop_c)
  );

  i2c_ee_link #(.ADDR_W(ADDR_W)) u_link (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_c   (start_c),
    .stop_c    (stop_c),
    .dev_addr  (dev_addr),
    .rd_data   (rd_data),
    .sda_oe    (sda_oe),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata),
    .ptr_q     (ptr_q)
  );

  i2c_ee_store #(
    .ADDR_W (ADDR_W),
    .DATA_W (BYTE_W),
    .INIT   (INIT_IMAGE)
  ) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (ptr_q),
    .rdata (rd_data)
  );

endmodule

// File: rtl/i2c_eeprom_target_chk.sv
module i2c_eeprom_target_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sda_oe,
  input logic              scl_fall,
  input logic              start_c,
  input logic              stop_c,
  input logic              mem_we,
  input logic [ADDR_W-1:0] ptr_q
);

  // R10: the drive only moves right after a synchronized SCL fall
  p_oe_after_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall));

  // R10: START leaves SDA released
  p_start_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> !sda_oe);

  // R10: STOP leaves SDA released
  p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> !sda_oe);

  // R2: every stored byte is acknowledged
  p_write_acked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> sda_oe);

  // R5 / R4: the pointer either steps by one or reloads when a phase closes
  p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ptr_q) |-> ((ptr_q == ADDR_W'($past(ptr_q) + 1'b1)) || $past(start_c || stop_c)));

endmodule

bind i2c_eeprom_target i2c_eeprom_target_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/i2c_eeprom_target_bench.sv
module i2c_eeprom_target_bench;

  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] strap_idx = 3'd3;
  logic       scl_drv = 1'b1;
  logic       sda_pull = 1'b0;
  logic       sda_oe;
  logic       sda_line;

  int nvec = 0;
  int nerr = 0;
  int cyc = 0;
  bit done = 1'b0;

  int mem_m [256];
  int ptr_m;

  always #5 clk = ~clk;

  assign sda_line = ~(sda_pull | sda_oe);

  i2c_eeprom_target u_i2c_eeprom_target (
    .clk       (clk),
    .rst_n     (rst_n),
    .strap_idx (strap_idx),
    .scl_in    (scl_drv),
    .sda_in    (sda_line),
    .sda_oe    (sda_oe)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      nvec++;
      nerr++;
      $display("FAIL watchdog: actual timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n = 1);
    repeat (n * Q) @(posedge clk);
  endtask

  // One SCL pulse; b = level host leaves on SDA, exp_oe = expected target drive
  task automatic host_bit(input logic b, input logic exp_oe, input string req,
                          output logic seen);
    scl_drv = 1'b0;
    wq();
    sda_pull = ~b;
    wq();
    scl_drv = 1'b1;
    wq();
    @(negedge clk);
    seen = sda_line;
    check(req, int'(sda_oe), int'(exp_oe));
    wq();
    scl_drv = 1'b0;
  endtask

  task automatic start_cond();
    wq();
    sda_pull = 1'b0;
    wq();
    scl_drv = 1'b1;
    wq(2);
    sda_pull = 1'b1;
    wq(2);
    scl_drv = 1'b0;
  endtask

  task automatic stop_cond();
    scl_drv = 1'b0;
    wq();
    sda_pull = 1'b1;
    wq();
    scl_drv = 1'b1;
    wq(2);
    sda_pull = 1'b0;
    wq(2);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string req);
    logic s;
    for (int i = 7; i >= 0; i--) host_bit(b[i], 1'b0, req, s);
    host_bit(1'b1, exp_ack, req, s);
  endtask

  task automatic recv_byte(input logic [7:0] exp, input logic host_ack, input string req);
    logic s;
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) begin
      host_bit(1'b1, ~exp[i], req, s);
      got[i] = s;
    end
    check(req, int'(got), int'(exp));
    host_bit(~host_ack, 1'b0, req, s);
  endtask

  task automatic do_read(input logic [6:0] a, input int n, input string req);
    start_cond();
    send_byte({a, 1'b1}, 1'b1, "R1 R2");
    for (int k = 0; k < n; k++) begin
      recv_byte(8'(mem_m[ptr_m]), k != n - 1, req);
      ptr_m = (ptr_m + 1) % 256;
    end
    stop_cond();
  endtask

  task automatic do_write(input logic [6:0] a, input int bytes [$], input string req);
    start_cond();
    send_byte({a, 1'b0}, 1'b1, "R1 R2");
    foreach (bytes[k]) send_byte(8'(bytes[k]), 1'b1, "R2");
    stop_cond();
    if (bytes.size() == 1) ptr_m = bytes[0];
    else if (bytes.size() > 1)
      for (int k = 1; k < bytes.size(); k++) mem_m[(bytes[0] + k - 1) % 256] = bytes[k];
  endtask

  initial begin
    logic s;
    for (int k = 0; k < 256; k++) mem_m[k] = k ^ 'hA5;
    ptr_m = 0;
    wq(2);
    rst_n = 1'b1;
    wq(2);
    @(negedge clk);
    check("R3 reset drive", int'(sda_oe), 0);

    // R3 R5: read from pointer 0, last byte NACKed
    do_read(7'h53, 3, "R5 R3");

    // R9: after a NACK the target stays off the line while SCL keeps toggling
    start_cond();
    send_byte({7'h53, 1'b1}, 1'b1, "R1");
    recv_byte(8'(mem_m[ptr_m]), 1'b0, "R9");
    ptr_m = (ptr_m + 1) % 256;
    for (int i = 0; i < 9; i++) host_bit(1'b1, 1'b0, "R9", s);
    stop_cond();

    // R1: wrong address is not acknowledged, following byte ignored
    start_cond();
    send_byte({7'h52, 1'b0}, 1'b0, "R1 mismatch");
    send_byte(8'h00, 1'b0, "R1 silent");
    stop_cond();

    // R8: quick write command, then confirm pointer and contents untouched
    begin
      int none [$];
      do_write(7'h53, none, "R8");
    end
    do_read(7'h53, 1, "R8");

    // R4: single byte sets pointer; R5 wrap over 255
    do_write(7'h53, '{8'hFE}, "R4");
    do_read(7'h53, 3, "R4 R5 wrap");

    // R6: page write wrapping over 255, pointer unchanged
    do_write(7'h53, '{8'hFD, 8'h11, 8'h22, 8'h33, 8'h44}, "R6");
    do_read(7'h53, 1, "R6 pointer kept");

    // R7 R10: command byte, repeated START, read
    start_cond();
    send_byte({7'h53, 1'b0}, 1'b1, "R1");
    send_byte(8'hFE, 1'b1, "R2");
    start_cond();
    send_byte({7'h53, 1'b1}, 1'b1, "R10 restart");
    ptr_m = 'hFE;
    for (int k = 0; k < 4; k++) begin
      recv_byte(8'(mem_m[ptr_m]), k != 3, "R7");
      ptr_m = (ptr_m + 1) % 256;
    end
    stop_cond();

    // R1: strap index moves the address
    strap_idx = 3'd0;
    wq(2);
    start_cond();
    send_byte({7'h53, 1'b0}, 1'b0, "R1 old address");
    stop_cond();
    do_read(7'h50, 2, "R1 strap 0");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule